// File: doc/BRIEF.md
# Two-Sequence PWM Playback Controller

This block sits between a value fetcher and the pulse generator of a four-channel PWM unit. It decides which duty value plays next and when playback starts, advances, pauses and ends. Tasks reach it as one-clock pulses: start sequence 0, start sequence 1, stop, and next step. It reports what happens through one-clock event pulses. For each of the two sequences it takes three settings from configuration inputs: a length, a refresh count (extra periods per value) and an end delay (extra periods after the last value). A loop count and a five-bit shortcut mask are also configuration inputs. The configuration must stay steady while playback runs.

A fetch request is a one-clock pulse on `fetch_o`. It carries the sequence number and the value index to load. The pulse generator reports the end of each PWM period on `period_end_i`. In automatic step mode, period ends drive the advance. In triggered step mode, the next-step task drives it. When the loop count is nonzero, sequence 0 and sequence 1 play as a pair, and a loops-done event marks the end of the whole run.

The controller is a five-state machine:
- IDLE: no pulses.
- PLAY: a value is playing.
- DELAY: the end delay is running.
- HOLD: playback is finished and the last value keeps playing.
- STOPPING: waiting for the current period to end.

Transitions:
- IDLE or HOLD to PLAY on an accepted start.
- PLAY to PLAY on a value advance or a sequence switch.
- PLAY to DELAY when a sequence ends and its end delay is nonzero.
- PLAY to HOLD at a final end.
- DELAY to PLAY (switch) or to HOLD when the delay expires.
- PLAY, DELAY or HOLD to STOPPING on a stop.
- STOPPING to IDLE on the next period end.

Top module: `pwm_seq_ctrl`

## Requirements
- R1: After reset, `run_o` and every fetch and event output are low.
- R2: A start is accepted only in IDLE or HOLD, and only when the requested sequence has a nonzero length. In loop mode both lengths must also be nonzero. On the clock after an accepted start, `fetch_o` pulses with index 0 for that sequence, the matching `ev_started_o` bit pulses, and `run_o` goes high. A start in any other state, or for a zero length, is ignored.
- R3: In automatic mode (`step_mode_i`=0), each value stays in play for refresh+1 period ends. The next fetch follows the last of those period ends by one clock.
- R4: `ev_seqend_o[n]` pulses in the same cycle as the fetch of the last index (length-1) of sequence n.
- R5: In automatic mode, once the last value has run its periods, the block waits end-delay more period ends. It then holds the last value (no loop) or switches to the other sequence (loop).
- R6: In triggered mode (`step_mode_i`=1), only a next-step task advances the index. Period ends never advance it, and refresh and end delay are ignored.
- R7: With a nonzero loop count L, a run plays sequence 0 then sequence 1 as a pair, L times; each end of sequence 1 counts one loop. On the last value of the final sequence 1, refresh and end delay are skipped. That value's first period end gives `ev_loops_done_o` and HOLD.
- R8: `ev_period_o` pulses one clock after each `period_end_i` while `run_o` is high, and never while it is low.
- R9: A stop in PLAY, DELAY or HOLD waits for the next period end. `ev_stopped_o` then pulses and `run_o` falls in the same cycle. A stop in IDLE is ignored.
- R10: Shortcut bits are: bit 0 sequence-end 0 to stop, bit 1 sequence-end 1 to stop, bit 2 loops-done to start 0, bit 3 loops-done to start 1, bit 4 loops-done to stop. An enabled link applies its task on the clock after its source event.
- R11: When tasks coincide, an accepted stop overrides any start, and start 0 overrides start 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 2 | Start task per sequence (one-clock pulse) |
| stop_i | input | 1 | Stop task |
| step_i | input | 1 | Next-step task |
| period_end_i | input | 1 | End-of-period strobe from the pulse generator |
| step_mode_i | input | 1 | 0 automatic, 1 triggered |
| loop_cnt_i | input | LOOP_W | Pair loop count, 0 disables looping |
| seq0_len_i | input | LEN_W | Value count of sequence 0 |
| seq1_len_i | input | LEN_W | Value count of sequence 1 |
| seq0_refresh_i | input | CNT_W | Extra periods per value, sequence 0 |
| seq1_refresh_i | input | CNT_W | Extra periods per value, sequence 1 |
| seq0_delay_i | input | CNT_W | End delay in periods, sequence 0 |
| seq1_delay_i | input | CNT_W | End delay in periods, sequence 1 |
| shortcut_i | input | 5 | Event-to-task link enables |
| run_o | output | 1 | Pulse generator enabled |
| fetch_o | output | 1 | Load-next-value request |
| fetch_seq_o | output | 1 | Sequence of the requested value |
| fetch_idx_o | output | LEN_W | Index of the requested value |
| ev_started_o | output | 2 | Sequence started event per sequence |
| ev_seqend_o | output | 2 | Last value fetched event per sequence |
| ev_period_o | output | 1 | Period end event |
| ev_loops_done_o | output | 1 | Looped playback complete event |
| ev_stopped_o | output | 1 | Stopped event |

## Verification
The hardest situation to reach is the final end of a looped run. Here the block must drop the refresh count and end delay, raise loops-done, and then act on shortcut tasks that it issues to itself one clock later. The bench gets there with a loop count of 2 and nonzero refresh and delay on both sequences. It counts period ends through every pair, so that a wrongly applied repeat or delay moves the loops-done pulse off its expected period. A second run enables loops-done to start 1 together with loops-done to stop. That run shows the stop winning over the self-issued start, with no started event and a stopped event at the following period end.

// File: rtl/pwm_seq_pkg.sv
package pwm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAY,
        ST_DELAY,
        ST_HOLD,
        ST_STOPPING
    } pwm_state_e;

    // shortcut mask bit positions
    localparam int SC_END0_STOP   = 0;
    localparam int SC_END1_STOP   = 1;
    localparam int SC_DONE_START0 = 2;
    localparam int SC_DONE_START1 = 3;
    localparam int SC_DONE_STOP   = 4;
    localparam int SC_W           = 5;

endpackage

// File: rtl/pwm_task_merge.sv
module pwm_task_merge
    import pwm_seq_pkg::*;
(
    input  logic [1:0]      start_i,
    input  logic            stop_i,
    input  logic            step_i,
    input  logic [SC_W-1:0] shortcut_i,
    input  logic [1:0]      seqend_ev_i,
    input  logic            done_ev_i,
    output logic [1:0]      start_o,
    output logic            stop_o,
    output logic            step_o
);

    logic [1:0] end_stop;

    // each sequence-end event may request a stop through its own mask bit
    for (genvar s = 0; s < 2; s++) begin : g_end_stop
        assign end_stop[s] = seqend_ev_i[s] && shortcut_i[SC_END0_STOP + s];
    end

    assign start_o[0] = start_i[0] | (done_ev_i & shortcut_i[SC_DONE_START0]);
    assign start_o[1] = start_i[1] | (done_ev_i & shortcut_i[SC_DONE_START1]);
    assign stop_o     = stop_i | (|end_stop) | (done_ev_i & shortcut_i[SC_DONE_STOP]);
    assign step_o     = step_i;

endmodule

// File: rtl/pwm_period_tally.sv
module pwm_period_tally #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= '0;
        end else if (clr_i) begin
            q_o <= '0;
        end else if (inc_i) begin
            q_o <= q_o + W'(1);
        end
    end

endmodule

// File: rtl/pwm_seq_ctrl.sv
module pwm_seq_ctrl
    import pwm_seq_pkg::*;
#(
    parameter int LEN_W  = 15,
    parameter int CNT_W  = 24,
    parameter int LOOP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        start_i,
    input  logic              stop_i,
    input  logic              step_i,
    input  logic              period_end_i,
    input  logic              step_mode_i,
    input  logic [LOOP_W-1:0] loop_cnt_i,
    input  logic [LEN_W-1:0]  seq0_len_i,
    input  logic [LEN_W-1:0]  seq1_len_i,
    input  logic [CNT_W-1:0]  seq0_refresh_i,
    input  logic [CNT_W-1:0]  seq1_refresh_i,
    input  logic [CNT_W-1:0]  seq0_delay_i,
    input  logic [CNT_W-1:0]  seq1_delay_i,
    input  logic [SC_W-1:0]   shortcut_i,
    output logic              run_o,
    output logic              fetch_o,
    output logic              fetch_seq_o,
    output logic [LEN_W-1:0]  fetch_idx_o,
    output logic [1:0]        ev_started_o,
    output logic [1:0]        ev_seqend_o,
    output logic              ev_period_o,
    output logic              ev_loops_done_o,
    output logic              ev_stopped_o
);

    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [LOOP_W-1:0] LOOP_ONE = LOOP_W'(1);

    // ---------------- state ----------------
    pwm_state_e        state, nxt_state;
    logic              cur_seq, nxt_seq;
    logic [LEN_W-1:0]  idx, nxt_idx;
    logic [LOOP_W-1:0] loops_left, nxt_loops;
    logic              loop_on, nxt_loop_on;

    // ---------------- effective tasks ----------------
    logic [1:0] eff_start;
    logic       eff_stop, eff_step;

    pwm_task_merge u_merge (
        .start_i     (start_i),
        .stop_i      (stop_i),
        .step_i      (step_i),
        .shortcut_i  (shortcut_i),
        .seqend_ev_i (ev_seqend_o),
        .done_ev_i   (ev_loops_done_o),
        .start_o     (eff_start),
        .stop_o      (eff_stop),
        .step_o      (eff_step)
    );

    // ---------------- period tally ----------------
    logic             tal_clr, tal_inc;
    logic [CNT_W-1:0] tally_q;

    pwm_period_tally #(.W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (tal_clr),
        .inc_i (tal_inc),
        .q_o   (tally_q)
    );

    // ---------------- per-sequence config selection ----------------
    logic [LEN_W-1:0] len_a [2];
    logic [CNT_W-1:0] ref_a [2];
    logic [CNT_W-1:0] dly_a [2];

    assign len_a[0] = seq0_len_i;
    assign len_a[1] = seq1_len_i;
    assign ref_a[0] = seq0_refresh_i;
    assign ref_a[1] = seq1_refresh_i;
    assign dly_a[0] = seq0_delay_i;
    assign dly_a[1] = seq1_delay_i;

    logic             other_seq;
    logic [LEN_W-1:0] len_cur;
    logic [CNT_W-1:0] ref_cur, dly_cur;
    logic             last_val, final_seq;

    assign other_seq = ~cur_seq;
    assign len_cur   = len_a[cur_seq];
    assign ref_cur   = ref_a[cur_seq];
    assign dly_cur   = dly_a[cur_seq];
    assign last_val  = (idx == len_cur - LEN_ONE);
    assign final_seq = loop_on && cur_seq && (loops_left == LOOP_ONE);

    // ---------------- start qualification ----------------
    logic start_req, start_sel, start_ok, stop_acc;

    assign start_req = |eff_start;
    assign start_sel = eff_start[0] ? 1'b0 : 1'b1;
    assign start_ok  = start_req && (len_a[start_sel] != '0) &&
                       ((loop_cnt_i == '0) || ((seq0_len_i != '0) && (seq1_len_i != '0)));
    assign stop_acc  = eff_stop && (state != ST_IDLE) && (state != ST_STOPPING);

    // ---------------- next-state logic ----------------
    logic             launch, seq_switch, to_hold, val_done;
    logic             do_fetch, fetch_seq_n;
    logic [LEN_W-1:0] fetch_idx_n;
    logic [1:0]       started_n, seqend_n;
    logic             done_n, stopped_n, period_n;

    always_comb begin
        nxt_state   = state;
        nxt_seq     = cur_seq;
        nxt_idx     = idx;
        nxt_loops   = loops_left;
        nxt_loop_on = loop_on;
        tal_clr     = 1'b0;
        tal_inc     = 1'b0;
        launch      = 1'b0;
        seq_switch  = 1'b0;
        to_hold     = 1'b0;
        val_done    = 1'b0;
        do_fetch    = 1'b0;
        fetch_seq_n = cur_seq;
        fetch_idx_n = idx;
        started_n   = '0;
        done_n      = 1'b0;
        stopped_n   = 1'b0;

        unique case (state)
            ST_IDLE, ST_HOLD: begin
                if (stop_acc) begin
                    nxt_state = ST_STOPPING;
                end else if (start_ok) begin
                    launch = 1'b1;
                end
            end
            ST_PLAY: begin
                if (stop_acc) begin
                    nxt_state = ST_STOPPING;
                end else begin
                    if (step_mode_i) begin
                        val_done = eff_step;
                    end else begin
                        val_done = period_end_i &&
                                   ((tally_q == ref_cur) || (final_seq && last_val));
                        tal_inc  = period_end_i && !val_done;
                    end
                    if (val_done) begin
                        if (!last_val) begin
                            nxt_idx     = idx + LEN_ONE;
                            tal_clr     = 1'b1;
                            do_fetch    = 1'b1;
                            fetch_idx_n = idx + LEN_ONE;
                        end else if (final_seq) begin
                            done_n  = 1'b1;
                            to_hold = 1'b1;
                        end else if (!step_mode_i && (dly_cur != '0)) begin
                            nxt_state = ST_DELAY;
                            tal_clr   = 1'b1;
                        end else if (loop_on) begin
                            seq_switch = 1'b1;
                        end else begin
                            to_hold = 1'b1;
                        end
                    end
                end
            end
            ST_DELAY: begin
                if (stop_acc) begin
                    nxt_state = ST_STOPPING;
                end else if (period_end_i) begin
                    if (tally_q == dly_cur - CNT_ONE) begin
                        if (loop_on) seq_switch = 1'b1;
                        else         to_hold    = 1'b1;
                    end else begin
                        tal_inc = 1'b1;
                    end
                end
            end
            ST_STOPPING: begin
                if (period_end_i) begin
                    nxt_state = ST_IDLE;
                    stopped_n = 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase

        if (launch) begin
            nxt_state            = ST_PLAY;
            nxt_seq              = start_sel;
            nxt_idx              = '0;
            nxt_loops            = loop_cnt_i;
            nxt_loop_on          = (loop_cnt_i != '0);
            tal_clr              = 1'b1;
            do_fetch             = 1'b1;
            fetch_seq_n          = start_sel;
            fetch_idx_n          = '0;
            started_n[start_sel] = 1'b1;
        end

        if (seq_switch) begin
            nxt_state            = ST_PLAY;
            nxt_seq              = other_seq;
            nxt_idx              = '0;
            tal_clr              = 1'b1;
            if (cur_seq) nxt_loops = loops_left - LOOP_ONE;
            do_fetch             = 1'b1;
            fetch_seq_n          = other_seq;
            fetch_idx_n          = '0;
            started_n[other_seq] = 1'b1;
        end

        if (to_hold) begin
            nxt_state = ST_HOLD;
        end
    end

    for (genvar s = 0; s < 2; s++) begin : g_seqend
        assign seqend_n[s] = do_fetch && (fetch_seq_n == s[0]) &&
                             (fetch_idx_n == len_a[s] - LEN_ONE);
    end

    assign period_n = period_end_i && (state != ST_IDLE);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur_seq    <= 1'b0;
            idx        <= '0;
            loops_left <= '0;
            loop_on    <= 1'b0;
        end else begin
            state      <= nxt_state;
            cur_seq    <= nxt_seq;
            idx        <= nxt_idx;
            loops_left <= nxt_loops;
            loop_on    <= nxt_loop_on;
        end
    end

    // ---------------- registered outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_o         <= 1'b0;
            fetch_seq_o     <= 1'b0;
            fetch_idx_o     <= '0;
            ev_started_o    <= '0;
            ev_seqend_o     <= '0;
            ev_period_o     <= 1'b0;
            ev_loops_done_o <= 1'b0;
            ev_stopped_o    <= 1'b0;
        end else begin
            fetch_o         <= do_fetch;
            if (do_fetch) begin
                fetch_seq_o <= fetch_seq_n;
                fetch_idx_o <= fetch_idx_n;
            end
            ev_started_o    <= started_n;
            ev_seqend_o     <= seqend_n;
            ev_period_o     <= period_n;
            ev_loops_done_o <= done_n;
            ev_stopped_o    <= stopped_n;
        end
    end

    assign run_o = (state != ST_IDLE);

    // ---------------- assertions ----------------
    a_r2_started_fetches_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_started_o) |-> (fetch_o && (fetch_idx_o == '0) && run_o));

    a_r2_one_start_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev_started_o));

    a_r4_seqend_with_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_seqend_o) |-> (fetch_o && ev_seqend_o[fetch_seq_o]));

    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ev_loops_done_o |-> (state == ST_HOLD));

    a_r8_no_period_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !$past(run_o)) |-> ##1 !ev_period_o);

    a_r9_stopped_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stopped_o |-> (!run_o && $past(state == ST_STOPPING)));

    a_r9_fetch_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> run_o);

endmodule

// File: tb/tb_pwm_seq_ctrl.sv
module tb_pwm_seq_ctrl;

    localparam int LEN_W  = 15;
    localparam int CNT_W  = 24;
    localparam int LOOP_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        start_i = '0;
    logic              stop_i = 1'b0;
    logic              step_i = 1'b0;
    logic              period_end_i = 1'b0;
    logic              step_mode_i = 1'b0;
    logic [LOOP_W-1:0] loop_cnt_i = '0;
    logic [LEN_W-1:0]  seq0_len_i = '0, seq1_len_i = '0;
    logic [CNT_W-1:0]  seq0_refresh_i = '0, seq1_refresh_i = '0;
    logic [CNT_W-1:0]  seq0_delay_i = '0, seq1_delay_i = '0;
    logic [4:0]        shortcut_i = '0;
    logic              run_o, fetch_o, fetch_seq_o;
    logic [LEN_W-1:0]  fetch_idx_o;
    logic [1:0]        ev_started_o, ev_seqend_o;
    logic              ev_period_o, ev_loops_done_o, ev_stopped_o;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pwm_seq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W), .LOOP_W(LOOP_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .step_i(step_i),
        .period_end_i(period_end_i), .step_mode_i(step_mode_i), .loop_cnt_i(loop_cnt_i),
        .seq0_len_i(seq0_len_i), .seq1_len_i(seq1_len_i),
        .seq0_refresh_i(seq0_refresh_i), .seq1_refresh_i(seq1_refresh_i),
        .seq0_delay_i(seq0_delay_i), .seq1_delay_i(seq1_delay_i),
        .shortcut_i(shortcut_i), .run_o(run_o), .fetch_o(fetch_o),
        .fetch_seq_o(fetch_seq_o), .fetch_idx_o(fetch_idx_o),
        .ev_started_o(ev_started_o), .ev_seqend_o(ev_seqend_o),
        .ev_period_o(ev_period_o), .ev_loops_done_o(ev_loops_done_o),
        .ev_stopped_o(ev_stopped_o)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    // apply inputs for one clock; on return the outputs of that edge are visible
    task automatic tick(input logic [1:0] st, input logic sp, input logic nx, input logic pe);
        start_i = st; stop_i = sp; step_i = nx; period_end_i = pe;
        @(negedge clk);
        start_i = '0; stop_i = 1'b0; step_i = 1'b0; period_end_i = 1'b0;
    endtask

    task automatic period();
        tick(2'b00, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic fetch_chk(input string req, input int f, input int s, input int i);
        chk(req, "fetch", fetch_o, f);
        if (f != 0) begin
            chk(req, "fetch_seq", fetch_seq_o, s);
            chk(req, "fetch_idx", fetch_idx_o, i);
        end
    endtask

    task automatic stop_and_drain(input string req);
        tick(2'b00, 1'b1, 1'b0, 1'b0);
        chk(req, "run during stopping", run_o, 1);
        period();
        chk(req, "stopped event", ev_stopped_o, 1);
        chk(req, "run after stop", run_o, 0);
    endtask

    task automatic t_reset();
        chk("R1", "run", run_o, 0);
        chk("R1", "fetch", fetch_o, 0);
        chk("R1", "events", {ev_started_o, ev_seqend_o, ev_period_o, ev_loops_done_o, ev_stopped_o}, 0);
    endtask

    task automatic t_auto_single();
        step_mode_i = 0; loop_cnt_i = 0; shortcut_i = 0;
        seq0_len_i = 3; seq0_refresh_i = 1; seq0_delay_i = 2; seq1_len_i = 1;
        tick(2'b01, 0, 0, 0);
        fetch_chk("R2", 1, 0, 0);
        chk("R2", "started", ev_started_o, 1);
        chk("R2", "run", run_o, 1);
        chk("R4", "no seqend on first", ev_seqend_o, 0);
        tick(2'b10, 0, 0, 0);
        chk("R2", "start while playing ignored", ev_started_o, 0);
        fetch_chk("R2", 0, 0, 0);
        period();
        fetch_chk("R3", 0, 0, 0);
        chk("R8", "period event", ev_period_o, 1);
        period();
        fetch_chk("R3", 1, 0, 1);
        period();
        period();
        fetch_chk("R3", 1, 0, 2);
        chk("R4", "seqend0", ev_seqend_o, 1);
        period();
        period();
        fetch_chk("R5", 0, 0, 0);
        period();
        fetch_chk("R5", 0, 0, 0);
        period();
        fetch_chk("R5", 0, 0, 0);
        chk("R5", "still running in hold", run_o, 1);
        // now in hold: a start is accepted
        tick(2'b10, 0, 0, 0);
        chk("R5", "start accepted after delay", ev_started_o, 2);
        fetch_chk("R2", 1, 1, 0);
        stop_and_drain("R9");
    endtask

    task automatic t_zero_len_and_idle_stop();
        seq1_len_i = 0;
        tick(2'b10, 0, 0, 0);
        chk("R2", "zero length start ignored", ev_started_o, 0);
        chk("R2", "zero length run", run_o, 0);
        tick(2'b00, 1, 0, 0);
        period();
        chk("R9", "stop in idle no event", ev_stopped_o, 0);
        chk("R8", "no period event idle", ev_period_o, 0);
    endtask

    task automatic t_priority();
        seq0_len_i = 1; seq1_len_i = 1; loop_cnt_i = 0; step_mode_i = 0;
        seq0_refresh_i = 0; seq0_delay_i = 0;
        tick(2'b11, 0, 0, 0);
        chk("R11", "start0 wins", ev_started_o, 1);
        stop_and_drain("R11");
    endtask

    task automatic t_triggered();
        step_mode_i = 1; loop_cnt_i = 0; shortcut_i = 0;
        seq0_len_i = 2; seq0_refresh_i = 5; seq0_delay_i = 5; seq1_len_i = 1;
        tick(2'b01, 0, 0, 0);
        fetch_chk("R6", 1, 0, 0);
        period();
        fetch_chk("R6", 0, 0, 0);
        chk("R8", "period event triggered", ev_period_o, 1);
        tick(2'b00, 0, 1, 0);
        fetch_chk("R6", 1, 0, 1);
        chk("R4", "seqend0 triggered", ev_seqend_o, 1);
        tick(2'b00, 0, 1, 0);
        fetch_chk("R6", 0, 0, 0);
        tick(2'b10, 0, 0, 0);
        chk("R6", "no end delay, start accepted", ev_started_o, 2);
        period();
        fetch_chk("R6", 0, 0, 0);
        stop_and_drain("R9");
        step_mode_i = 0;
    endtask

    task automatic t_loop();
        step_mode_i = 0; shortcut_i = 0; loop_cnt_i = 2;
        seq0_len_i = 1; seq1_len_i = 2;
        seq0_refresh_i = 1; seq1_refresh_i = 1; seq0_delay_i = 1; seq1_delay_i = 1;
        tick(2'b01, 0, 0, 0);
        fetch_chk("R7", 1, 0, 0);
        chk("R4", "seqend0 len1", ev_seqend_o, 1);
        period(); period(); period();
        fetch_chk("R7", 1, 1, 0);
        chk("R7", "started1", ev_started_o, 2);
        period(); period();
        fetch_chk("R7", 1, 1, 1);
        chk("R4", "seqend1", ev_seqend_o, 2);
        period(); period(); period();
        fetch_chk("R7", 1, 0, 0);
        chk("R7", "second pair started0", ev_started_o, 1);
        chk("R7", "no early done", ev_loops_done_o, 0);
        period(); period(); period();
        fetch_chk("R7", 1, 1, 0);
        period(); period();
        fetch_chk("R7", 1, 1, 1);
        period();
        chk("R7", "loops done no refresh", ev_loops_done_o, 1);
        fetch_chk("R7", 0, 0, 0);
        chk("R7", "run in hold", run_o, 1);
        stop_and_drain("R9");
    endtask

    task automatic t_short_end_stop();
        loop_cnt_i = 0; shortcut_i = 5'b00001;
        seq0_len_i = 2; seq0_refresh_i = 0; seq0_delay_i = 0;
        tick(2'b01, 0, 0, 0);
        fetch_chk("R10", 1, 0, 0);
        period();
        chk("R10", "seqend0", ev_seqend_o, 1);
        tick(2'b00, 0, 0, 0);
        chk("R10", "still running", run_o, 1);
        period();
        chk("R10", "stopped via shortcut", ev_stopped_o, 1);
        chk("R10", "run low", run_o, 0);
    endtask

    task automatic t_short_done();
        loop_cnt_i = 1; shortcut_i = 5'b11000;
        seq0_len_i = 1; seq1_len_i = 1;
        seq0_refresh_i = 0; seq1_refresh_i = 0; seq0_delay_i = 0; seq1_delay_i = 0;
        tick(2'b01, 0, 0, 0);
        chk("R10", "started0", ev_started_o, 1);
        period();
        chk("R7", "switch to seq1", ev_started_o, 2);
        period();
        chk("R7", "loops done", ev_loops_done_o, 1);
        tick(2'b00, 0, 0, 0);
        chk("R11", "stop beats shortcut start", ev_started_o, 0);
        chk("R11", "stopping", run_o, 1);
        period();
        chk("R10", "stopped", ev_stopped_o, 1);
        shortcut_i = 5'b00100; loop_cnt_i = 1;
        tick(2'b01, 0, 0, 0);
        period();
        period();
        chk("R10", "done", ev_loops_done_o, 1);
        tick(2'b00, 0, 0, 0);
        chk("R10", "restart seq0 via shortcut", ev_started_o, 1);
        shortcut_i = 0;
        stop_and_drain("R10");
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_auto_single();
        t_zero_len_and_idle_stop();
        t_priority();
        t_triggered();
        t_loop();
        t_short_end_stop();
        t_short_done();
        finished = 1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            report();
        end
    end

endmodule